// File: doc/BRIEF.md
# Program Flow and Return Stack Unit

This block keeps the control-flow state of a small 8-bit controller core. It owns the 12-bit program counter, a four-slot hardware return stack and two banks of Zero/Carry status bits. Each cycle the surrounding core presents one flow operation: hold, advance, jump, call, return, return-from-interrupt or interrupt entry. The unit updates the program counter, saves or restores return addresses, and selects which status bank is active.

The return stack has no pointer visible to software and lives outside the data space. Calls and interrupts save the current program counter. By the time a call executes, the fetch stage has already advanced the counter past the call's operand bytes, so the saved value is the address of the following instruction. Status bits are preserved across an interrupt by switching to a second bank rather than by saving them. The arithmetic unit writes new Zero/Carry values through a write port, and the outputs always show the active bank.

Top module: `flow_ctrl_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the unit resets. Afterwards `pc_o` is 0, both status banks hold Z=0 and C=0, `irq_bank_o` is 0 (normal bank active), `stk_ovf_o` and `stk_unf_o` are 0, and the stack is empty.
- R2: The operation code on `op_i` is 3 bits wide. Code 1 (advance) adds one to `pc_o` on the next edge, and 0xFFF wraps to 0x000. Code 0 (hold) and the unused code 7 leave `pc_o` unchanged.
- R3: Code 2 (jump) loads `tgt_i` into `pc_o` and leaves the stack unchanged.
- R4: Code 3 (call) saves the current `pc_o` on the stack and loads `tgt_i`. It does not change the active status bank.
- R5: Code 4 (return) restores the most recently saved address into `pc_o`, in last-in first-out order, and does not change the active bank.
- R6: Code 6 (interrupt entry) saves the current `pc_o`, loads `tgt_i` as the vector and toggles the active bank. Code 5 (return-from-interrupt) restores the saved address and toggles the active bank back.
- R7: A save while four addresses are held overwrites the oldest one and sets the sticky output `stk_ovf_o`. The four most recent addresses remain restorable in last-in first-out order.
- R8: A restore (code 4 or 5) from an empty stack leaves `pc_o` unchanged and sets the sticky output `stk_unf_o`. A code 5 restore still toggles the active bank.
- R9: When `flag_we_i` is high, `zero_i` and `carry_i` are written into the active bank only. The inactive bank keeps its values, which become visible after the next toggle.
- R10: A status write in the same cycle as a bank toggle goes to the bank that becomes active.
- R11: `stk_ovf_o` and `stk_unf_o` stay at 1 once set, until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Flow operation: 0 hold, 1 advance, 2 jump, 3 call, 4 return, 5 return-from-interrupt, 6 interrupt entry, 7 hold |
| tgt_i | input | 12 | Jump or call target, or interrupt vector |
| flag_we_i | input | 1 | Write enable for the active status bank |
| zero_i | input | 1 | New Zero value |
| carry_i | input | 1 | New Carry value |
| pc_o | output | 12 | Program counter |
| zero_o | output | 1 | Zero bit of the active bank |
| carry_o | output | 1 | Carry bit of the active bank |
| irq_bank_o | output | 1 | 1 when the interrupt bank is active |
| stk_ovf_o | output | 1 | Sticky: a save overwrote the oldest address |
| stk_unf_o | output | 1 | Sticky: a restore found the stack empty |

## Verification
The program counter is driven with runs of advance codes, holds, the unused code and a jump to 0xFFF. Together these separate a correct increment and wrap from a counter that stalls, skips or ignores the unused code. Nested calls with distinct targets, followed by returns, show whether addresses come back in last-in first-out order and whether a plain return wrongly toggles the status bank. A five-deep chain of calls followed by five returns separates overwrite-oldest behaviour from overwrite-newest behaviour, and shows how an empty-stack restore is handled. Status writes placed before, during and after interrupt entry and exit reveal which bank each write reaches.

// File: rtl/fcu_pkg.sv
// Package: shared operation codes and widths for the flow control unit.
// Assumes a 3-bit operation field driven by the core's decode stage.
package fcu_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        FOP_HOLD  = 3'd0,
        FOP_STEP  = 3'd1,
        FOP_JUMP  = 3'd2,
        FOP_CALL  = 3'd3,
        FOP_RET   = 3'd4,
        FOP_RETI  = 3'd5,
        FOP_IRQ   = 3'd6,
        FOP_SPARE = 3'd7
    } flow_op_e;

    // Decoded control strobes produced from one operation code.
    typedef struct packed {
        logic step;
        logic load_tgt;
        logic push;
        logic pop;
        logic swap;
    } flow_ctl_t;
endpackage

// File: rtl/fcu_decode.sv
// Module: turns a flow operation code into one-hot-ish control strobes.
// Assumes push and pop are never requested together; code 7 acts as hold.
module fcu_decode
    import fcu_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output flow_ctl_t       ctl_o
);
    // Map each operation code onto its control strobes.
    always_comb begin
        ctl_o = '0;
        unique case (flow_op_e'(op_i))
            FOP_STEP: ctl_o.step = 1'b1;
            FOP_JUMP: ctl_o.load_tgt = 1'b1;
            FOP_CALL: begin
                ctl_o.load_tgt = 1'b1;
                ctl_o.push     = 1'b1;
            end
            FOP_RET:  ctl_o.pop = 1'b1;
            FOP_RETI: begin
                ctl_o.pop  = 1'b1;
                ctl_o.swap = 1'b1;
            end
            FOP_IRQ: begin
                ctl_o.load_tgt = 1'b1;
                ctl_o.push     = 1'b1;
                ctl_o.swap     = 1'b1;
            end
            default: ctl_o = '0;
        endcase
    end
endmodule

// File: rtl/fcu_retstack.sv
// Module: dedicated circular return stack with no visible pointer.
// A push when full overwrites the oldest slot; a pop when empty is refused.
// Assumes push and pop are mutually exclusive within a cycle.
module fcu_retstack #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [ADDR_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [ADDR_W-1:0] top_data_o,
    output logic              nonempty_o,
    output logic              ovf_o,
    output logic              unf_o
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    logic [ADDR_W-1:0] slot_q [DEPTH];
    logic [IDX_W-1:0]  top_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  up_idx;
    logic [IDX_W-1:0]  dn_idx;
    logic              full;

    assign full       = (cnt_q == FULL_CNT);
    assign nonempty_o = (cnt_q != '0);
    assign top_data_o = slot_q[top_q];

    // Neighbouring slot indices with explicit wrap for any depth.
    always_comb begin
        up_idx = (top_q == LAST_IDX) ? '0 : top_q + 1'b1;
        dn_idx = (top_q == '0) ? LAST_IDX : top_q - 1'b1;
    end

    // Storage slots: write the next slot above the top on push.
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot_q[i] <= '0;
                else if (push_i && up_idx == IDX_W'(i))
                    slot_q[i] <= push_data_i;
            end
        end
    endgenerate

    // Top index and occupancy count tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= LAST_IDX;
            cnt_q <= '0;
        end else if (push_i) begin
            top_q <= up_idx;
            if (!full)
                cnt_q <= cnt_q + 1'b1;
        end else if (pop_i && nonempty_o) begin
            top_q <= dn_idx;
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Sticky error flags, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_o <= 1'b0;
            unf_o <= 1'b0;
        end else begin
            if (push_i && full)
                ovf_o <= 1'b1;
            if (pop_i && !nonempty_o)
                unf_o <= 1'b1;
        end
    end

    // R7
    stk_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);
    // R7
    full_push_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full) |=> ovf_o);
    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);
    // R11
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |=> unf_o);
    // R8
    empty_pop_unf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !nonempty_o) |=> unf_o);
endmodule

// File: rtl/fcu_pc.sv
// Module: program counter register with increment, load and restore paths.
// Assumes at most one of step, load and restore is active per cycle.
module fcu_pc #(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] tgt_i,
    input  logic              restore_i,
    input  logic [ADDR_W-1:0] restore_data_i,
    output logic [ADDR_W-1:0] pc_o
);
    logic [ADDR_W-1:0] pc_d;

    // Select the next program counter value.
    always_comb begin
        pc_d = pc_o;
        if (load_i)
            pc_d = tgt_i;
        else if (restore_i)
            pc_d = restore_data_i;
        else if (step_i)
            pc_d = pc_o + 1'b1;
    end

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_o <= RESET_PC;
        else
            pc_o <= pc_d;
    end

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !restore_i) |=> pc_o == $past(pc_o) + 1'b1);
    // R3
    pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> pc_o == $past(tgt_i));
    // R2
    pc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !load_i && !restore_i) |=> $stable(pc_o));
endmodule

// File: rtl/fcu_flagbank.sv
// Module: two Zero/Carry banks with a selector for the active one.
// A toggle and a write in the same cycle land the write in the new bank.
module fcu_flagbank #(
    parameter int NBANK = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic swap_i,
    input  logic we_i,
    input  logic zero_i,
    input  logic carry_i,
    output logic zero_o,
    output logic carry_o,
    output logic sel_o
);
    logic [NBANK-1:0] z_q;
    logic [NBANK-1:0] c_q;
    logic             sel_d;

    assign sel_d   = swap_i ? ~sel_o : sel_o;
    assign zero_o  = z_q[sel_o];
    assign carry_o = c_q[sel_o];

    // Active-bank selector.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_o <= 1'b0;
        else
            sel_o <= sel_d;
    end

    // One Zero/Carry pair per bank, written only when it is the next active bank.
    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    z_q[b] <= 1'b0;
                    c_q[b] <= 1'b0;
                end else if (we_i && sel_d == 1'(b)) begin
                    z_q[b] <= zero_i;
                    c_q[b] <= carry_i;
                end
            end
        end
    endgenerate

    // R6
    bank_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_i |=> sel_o != $past(sel_o));
    // R5
    bank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_i |=> $stable(sel_o));
    // R10
    flag_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (zero_o == $past(zero_i)) && (carry_o == $past(carry_i)));
endmodule

// File: rtl/flow_ctrl_unit.sv
// Module: top of the flow control unit. Ties the decoder, program counter,
// return stack and status banks together. Calls and interrupts save the
// current program counter; fetch has already advanced it past the operands.
module flow_ctrl_unit
    import fcu_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                STK_DEPTH = 4,
    parameter logic [ADDR_W-1:0] RESET_PC  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic [ADDR_W-1:0] tgt_i,
    input  logic              flag_we_i,
    input  logic              zero_i,
    input  logic              carry_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic              zero_o,
    output logic              carry_o,
    output logic              irq_bank_o,
    output logic              stk_ovf_o,
    output logic              stk_unf_o
);
    flow_ctl_t         ctl;
    logic [ADDR_W-1:0] top_data;
    logic              nonempty;
    logic              restore;

    assign restore = ctl.pop && nonempty;

    fcu_decode u_dec (
        .op_i  (op_i),
        .ctl_o (ctl)
    );

    fcu_pc #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
        .clk            (clk),
        .rst_n          (rst_n),
        .step_i         (ctl.step),
        .load_i         (ctl.load_tgt),
        .tgt_i          (tgt_i),
        .restore_i      (restore),
        .restore_data_i (top_data),
        .pc_o           (pc_o)
    );

    fcu_retstack #(.DEPTH(STK_DEPTH), .ADDR_W(ADDR_W)) u_stk (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (ctl.push),
        .push_data_i (pc_o),
        .pop_i       (ctl.pop),
        .top_data_o  (top_data),
        .nonempty_o  (nonempty),
        .ovf_o       (stk_ovf_o),
        .unf_o       (stk_unf_o)
    );

    fcu_flagbank #(.NBANK(2)) u_flg (
        .clk     (clk),
        .rst_n   (rst_n),
        .swap_i  (ctl.swap),
        .we_i    (flag_we_i),
        .zero_i  (zero_i),
        .carry_i (carry_i),
        .zero_o  (zero_o),
        .carry_o (carry_o),
        .sel_o   (irq_bank_o)
    );

    // R4
    call_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == FOP_CALL) |=> (pc_o == $past(tgt_i)) && $stable(irq_bank_o));
    // R8
    empty_ret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.pop && !nonempty) |=> $stable(pc_o));
endmodule

// File: tb/flow_ctrl_unit_test.sv
// Bench: directed scenarios for the flow control unit, one task each.
module flow_ctrl_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [11:0] tgt_i = '0;
    logic        flag_we_i = 1'b0;
    logic        zero_i = 1'b0;
    logic        carry_i = 1'b0;
    logic [11:0] pc_o;
    logic        zero_o, carry_o, irq_bank_o, stk_ovf_o, stk_unf_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    flow_ctrl_unit uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .tgt_i(tgt_i),
        .flag_we_i(flag_we_i), .zero_i(zero_i), .carry_i(carry_i),
        .pc_o(pc_o), .zero_o(zero_o), .carry_o(carry_o),
        .irq_bank_o(irq_bank_o), .stk_ovf_o(stk_ovf_o), .stk_unf_o(stk_unf_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply one operation for one cycle; outputs are sampled on the next falling edge.
    task automatic op(input logic [2:0] code, input logic [11:0] tgt,
                      input logic we = 1'b0, input logic z = 1'b0, input logic c = 1'b0);
        op_i = code; tgt_i = tgt; flag_we_i = we; zero_i = z; carry_i = c;
        @(negedge clk);
        op_i = 3'd0; flag_we_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; op_i = 3'd0; flag_we_i = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 pc", pc_o, 0);
        check("R1 flags", {zero_o, carry_o}, 0);
        check("R1 bank", irq_bank_o, 0);
        check("R1 sticky", {stk_ovf_o, stk_unf_o}, 0);
    endtask

    task automatic t_step();
        do_reset();
        op(3'd1, 12'h0); op(3'd1, 12'h0); op(3'd1, 12'h0);
        check("R2 advance", pc_o, 3);
        op(3'd0, 12'h555);
        check("R2 hold", pc_o, 3);
        op(3'd7, 12'h555);
        check("R2 spare code", pc_o, 3);
        op(3'd2, 12'hFFF);
        check("R3 jump", pc_o, 12'hFFF);
        op(3'd1, 12'h0);
        check("R2 wrap", pc_o, 0);
    endtask

    task automatic t_call_ret();
        do_reset();
        op(3'd2, 12'h100);
        op(3'd3, 12'h200);
        check("R4 call target", pc_o, 12'h200);
        op(3'd1, 12'h0);
        op(3'd3, 12'h300);
        check("R4 nested call", pc_o, 12'h300);
        op(3'd4, 12'h0);
        check("R5 return inner", pc_o, 12'h201);
        op(3'd4, 12'h0);
        check("R5 return outer", pc_o, 12'h100);
        check("R5 bank unchanged", irq_bank_o, 0);
        check("R3 jump no push", stk_unf_o, 0);
        op(3'd4, 12'h0);
        check("R3 stack empty after", stk_unf_o, 1);
    endtask

    task automatic t_irq_banks();
        do_reset();
        op(3'd2, 12'h0A0);
        op(3'd0, 12'h0, 1'b1, 1'b1, 1'b0);
        check("R9 normal write", {zero_o, carry_o}, 2'b10);
        op(3'd6, 12'h040);
        check("R6 vector", pc_o, 12'h040);
        check("R6 bank toggled", irq_bank_o, 1);
        check("R9 irq bank untouched", {zero_o, carry_o}, 2'b00);
        op(3'd0, 12'h0, 1'b1, 1'b0, 1'b1);
        check("R9 irq bank write", {zero_o, carry_o}, 2'b01);
        op(3'd5, 12'h0);
        check("R6 reti pc", pc_o, 12'h0A0);
        check("R6 reti bank", irq_bank_o, 0);
        check("R9 normal restored", {zero_o, carry_o}, 2'b10);
        op(3'd6, 12'h050, 1'b1, 1'b1, 1'b1);
        check("R10 write on entry", {zero_o, carry_o}, 2'b11);
        op(3'd5, 12'h0, 1'b1, 1'b0, 1'b0);
        check("R10 write on exit", {zero_o, carry_o}, 2'b00);
        op(3'd6, 12'h060);
        check("R10 irq bank kept", {zero_o, carry_o}, 2'b11);
    endtask

    task automatic t_overflow();
        do_reset();
        op(3'd3, 12'h010); op(3'd3, 12'h020); op(3'd3, 12'h030); op(3'd3, 12'h040);
        check("R7 no ovf at four", stk_ovf_o, 0);
        op(3'd3, 12'h050);
        check("R7 ovf set", stk_ovf_o, 1);
        op(3'd4, 12'h0); check("R7 pop1", pc_o, 12'h040);
        op(3'd4, 12'h0); check("R7 pop2", pc_o, 12'h030);
        op(3'd4, 12'h0); check("R7 pop3", pc_o, 12'h020);
        op(3'd4, 12'h0); check("R7 pop4", pc_o, 12'h010);
        check("R8 no unf yet", stk_unf_o, 0);
        op(3'd4, 12'h0);
        check("R8 empty pc held", pc_o, 12'h010);
        check("R8 unf set", stk_unf_o, 1);
        op(3'd1, 12'h0);
        check("R11 ovf sticky", stk_ovf_o, 1);
        check("R11 unf sticky", stk_unf_o, 1);
    endtask

    task automatic t_empty_reti();
        do_reset();
        op(3'd5, 12'h0);
        check("R8 reti empty pc", pc_o, 0);
        check("R8 reti empty bank", irq_bank_o, 1);
        check("R8 reti empty unf", stk_unf_o, 1);
    endtask

    initial begin
        fork
            begin
                @(negedge clk);
                t_reset();
                t_step();
                t_call_ret();
                t_irq_banks();
                t_overflow();
                t_empty_reti();
            end
            begin
                repeat (5000) @(posedge clk);
                failures++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule